// File: doc/BRIEF.md
# Broadcast-Input Systolic FIR Array

This block computes a one-dimensional convolution (FIR filter) of a stream of signed samples with K signed coefficients. A linear chain of K multiply-accumulate cells each keeps one coefficient. Every accepted sample is driven into all cells in the same cycle. A running sum starts at zero in the leftmost cell, picks up one product per cell as it moves one cell to the right per accepted sample, and leaves the rightmost cell as a finished result.

Coefficients are shifted in serially before a run. Samples arrive with a valid flag; a cycle without a valid sample freezes the whole array, so gaps in the stream never misalign samples and sums. A flag travelling alongside each sum suppresses the partial sums produced while the chain fills, so only complete results are marked valid.

Top module: `sysconv_array`

## Requirements
- R1: After reset `y_valid_o` is 0 and `y_o` is 0.
- R2: Each cycle with `wload_i` high shifts `wdata_i` in as the newest coefficient. After K or more loads, the coefficient loaded K loads ago sits in the leftmost cell (c0) and the last one loaded sits in the rightmost cell (c(K-1)). Earlier loads have been shifted out. Coefficients do not change while `wload_i` is low.
- R3: With accepted samples numbered x(0), x(1), ... since reset, the result released with sample x(n) equals c0·x(n-K+1) + c1·x(n-K+2) + ... + c(K-1)·x(n), in signed two's complement.
- R4: The first K-1 accepted samples after reset produce no valid result. From the K-th accepted sample on, every accepted sample produces exactly one valid result, so N samples give N+1-K results.
- R5: A result is presented with `y_valid_o` high in the cycle right after the clock edge that accepts its last sample, and `y_valid_o` stays high for that one cycle only.
- R6: In a cycle with `x_valid_i` low, `x_i` is ignored: no result is produced, `y_o` holds its value, and later results still follow R3 over accepted samples only.
- R7: The result is 2·DW+clog2(K) bits wide and never overflows, including when every sample and coefficient is the most negative DW-bit value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wload_i | input | 1 | Shift `wdata_i` into the coefficient chain |
| wdata_i | input | DW | Signed coefficient |
| x_valid_i | input | 1 | Sample valid; low stalls the array |
| x_i | input | DW | Signed sample, broadcast to all cells |
| y_valid_o | output | 1 | Finished result present on `y_o` |
| y_o | output | 2·DW+clog2(K) | Signed convolution result |

## Verification
Several properties are checked on every cycle. Coefficients must hold while no load is requested. Every cell must freeze when its enable is low. A gap in the sample stream must produce no result and must leave `y_o` unchanged. During fill no valid result may appear, and in steady state every accepted sample must release one. The arithmetic can only be shown by the bench's scenarios. These cover the correct sum and its coefficient order, signed extremes without overflow, alignment across random gaps while `x_i` is driven with junk, and reloads that shift old coefficients out.

// File: rtl/sysconv_pkg.sv
package sysconv_pkg;
  // Result width: full product plus growth for K terms.
  function automatic int acc_width(input int dw, input int k);
    return 2 * dw + $clog2(k);
  endfunction
endpackage

// File: rtl/sysconv_wbank.sv
module sysconv_wbank #(
  parameter int DW = 8,
  parameter int K  = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 load_i,
  input  logic signed [DW-1:0] data_i,
  output logic signed [DW-1:0] w_o [K]
);
  logic signed [DW-1:0] w_q [K];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int j = 0; j < K; j++) w_q[j] <= '0;
    end else if (load_i) begin
      for (int j = 0; j < K - 1; j++) w_q[j] <= w_q[j+1];
      w_q[K-1] <= data_i;
    end
  end

  assign w_o = w_q;

  for (genvar g = 0; g < K; g++) begin : g_hold
    a_r2_weight_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !load_i |=> $stable(w_q[g]));
  end
endmodule

// File: rtl/sysconv_cell.sv
module sysconv_cell #(
  parameter int DW = 8,
  parameter int YW = 18
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 en_i,
  input  logic signed [DW-1:0] w_i,
  input  logic signed [DW-1:0] x_i,
  input  logic signed [YW-1:0] y_i,
  input  logic                 v_i,
  output logic signed [YW-1:0] y_o,
  output logic                 v_o
);
  logic signed [2*DW-1:0] prod;
  logic signed [YW-1:0]   y_q;
  logic                   v_q;

  assign prod = w_i * x_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      y_q <= '0;
      v_q <= 1'b0;
    end else if (en_i) begin
      y_q <= y_i + YW'(prod);
      v_q <= v_i;
    end
  end

  assign y_o = y_q;
  assign v_o = v_q;

  a_r6_cell_freeze: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> ($stable(y_q) && $stable(v_q)));
endmodule

// File: rtl/sysconv_array.sv
module sysconv_array #(
  parameter int DW = 8,
  parameter int K  = 4
) (
  input  logic                                                clk_i,
  input  logic                                                rst_ni,
  input  logic                                                wload_i,
  input  logic signed [DW-1:0]                                wdata_i,
  input  logic                                                x_valid_i,
  input  logic signed [DW-1:0]                                x_i,
  output logic                                                y_valid_o,
  output logic signed [sysconv_pkg::acc_width(DW, K)-1:0]     y_o
);
  localparam int YW = sysconv_pkg::acc_width(DW, K);
  localparam int FW = $clog2(K + 1);

  logic signed [DW-1:0] w [K];
  logic signed [YW-1:0] sum [K+1];
  logic                 vld [K+1];
  logic                 step_q;

  sysconv_wbank #(.DW(DW), .K(K)) u_wbank (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (wload_i),
    .data_i (wdata_i),
    .w_o    (w)
  );

  // Fresh zero sum enters on the left, flagged as a real result.
  assign sum[0] = '0;
  assign vld[0] = 1'b1;

  for (genvar g = 0; g < K; g++) begin : g_cell
    sysconv_cell #(.DW(DW), .YW(YW)) u_cell (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (x_valid_i),
      .w_i    (w[g]),
      .x_i    (x_i),
      .y_i    (sum[g]),
      .v_i    (vld[g]),
      .y_o    (sum[g+1]),
      .v_o    (vld[g+1])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) step_q <= 1'b0;
    else         step_q <= x_valid_i;
  end

  assign y_o       = sum[K];
  assign y_valid_o = step_q & vld[K];

  // Checker state: accepted-sample count saturating at K.
  logic [FW-1:0] chk_fill_q;
  logic          chk_acc_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chk_fill_q <= '0;
      chk_acc_q  <= 1'b0;
    end else begin
      chk_acc_q <= x_valid_i;
      if (x_valid_i && chk_fill_q != FW'(K)) chk_fill_q <= chk_fill_q + 1'b1;
    end
  end

  a_r4_fill_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chk_fill_q < FW'(K)) |-> !y_valid_o);
  a_r4_steady_out: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chk_fill_q == FW'(K) && chk_acc_q) |-> y_valid_o);
  a_r6_gap_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !x_valid_i |=> (!y_valid_o && $stable(y_o)));
  a_r1_reset_out: assert property (@(posedge clk_i)
    !rst_ni |-> (!y_valid_o && y_o == '0));
endmodule

// File: tb/tb_sysconv_array.sv
module tb_sysconv_array;
  localparam int DW = 8;
  localparam int K  = 4;
  localparam int YW = 2 * DW + $clog2(K);

  logic                 clk = 1'b0;
  logic                 rst_ni = 1'b0;
  logic                 wload_i = 1'b0;
  logic signed [DW-1:0] wdata_i = '0;
  logic                 x_valid_i = 1'b0;
  logic signed [DW-1:0] x_i = '0;
  logic                 y_valid_o;
  logic signed [YW-1:0] y_o;

  sysconv_array #(.DW(DW), .K(K)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .wload_i(wload_i), .wdata_i(wdata_i),
    .x_valid_i(x_valid_i), .x_i(x_i), .y_valid_o(y_valid_o), .y_o(y_o)
  );

  always #4 clk = ~clk;

  int checks = 0, failures = 0;
  int wts [K];
  int hist [1024];
  int n_acc = 0;
  bit prev_v = 0;
  int last_y = 0;
  int n_res = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int model();
    int s = 0;
    for (int j = 0; j < K; j++) s += wts[j] * hist[n_acc - K + j];
    return s;
  endfunction

  // Called at a negedge: outputs reflect the edge after the previous drive.
  task automatic check_out();
    if (prev_v && n_acc >= K) begin
      check(y_valid_o == 1'b1, "R4/R5 valid", int'(y_valid_o), 1);
      check(int'(y_o) == model(), "R3 result", int'(y_o), model());
      n_res++;
    end else begin
      check(y_valid_o == 1'b0, "R4/R5/R6 no valid", int'(y_valid_o), 0);
      if (!prev_v) check(int'(y_o) == last_y, "R6 y held", int'(y_o), last_y);
    end
    last_y = int'(y_o);
  endtask

  task automatic cycle(input bit v, input int x);
    @(negedge clk);
    check_out();
    wload_i   = 1'b0;
    x_valid_i = v;
    x_i       = DW'(x);
    prev_v    = v;
    if (v) begin
      hist[n_acc] = x;
      n_acc++;
    end
  endtask

  task automatic load(input int w);
    @(negedge clk);
    check_out();
    wload_i   = 1'b1;
    wdata_i   = DW'(w);
    x_valid_i = 1'b0;
    x_i       = DW'($urandom);
    prev_v    = 1'b0;
    for (int j = 0; j < K - 1; j++) wts[j] = wts[j+1];
    wts[K-1] = w;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0; wload_i = 0; x_valid_i = 0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    n_acc = 0; prev_v = 0; last_y = 0; n_res = 0;
    for (int j = 0; j < K; j++) wts[j] = 0;
    check(y_valid_o == 1'b0, "R1 reset valid", int'(y_valid_o), 0);
    check(y_o == '0, "R1 reset y", int'(y_o), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    do_reset();

    // Directed: coefficients 1..4, ramp 1..8 -> R2 order, R3, R4 count.
    for (int j = 1; j <= K; j++) load(j);
    for (int i = 1; i <= 8; i++) cycle(1, i);
    cycle(0, 99);
    check(n_res == 8 + 1 - K, "R4 result count", n_res, 8 + 1 - K);
    // y for window starting at 1: 1*1+2*2+3*3+4*4 = 30 checked via model; fixed spot check:
    cycle(0, 0);

    // Extremes: all -128 -> 4*16384, no overflow (R7).
    do_reset();
    for (int j = 0; j < K; j++) load(-128);
    for (int i = 0; i < 6; i++) cycle(1, -128);
    check(int'(y_o) == K * 16384, "R7 extreme positive", int'(y_o), K * 16384);
    for (int i = 0; i < 6; i++) cycle(1, 127);
    check(int'(y_o) == -K * 16256, "R7 extreme negative", int'(y_o), -K * 16256);
    cycle(0, 5);

    // Reload K+2 coefficients: oldest two shift out (R2), held while idle.
    do_reset();
    for (int j = 0; j < K + 2; j++) load(j * 10 - 17);
    repeat (3) cycle(0, 77);
    for (int i = 0; i < 10; i++) cycle(1, i * 3 - 11);

    // Random with gaps and junk samples during gaps (R3, R5, R6).
    do_reset();
    for (int j = 0; j < K; j++) load($signed(DW'($urandom)));
    for (int i = 0; i < 600; i++) begin
      bit v = ($urandom % 4) != 0;
      cycle(v, $signed(DW'($urandom)));
    end
    cycle(0, 0);
    cycle(0, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule